// File: doc/BRIEF.md
# UART Receive Path with Per-Character Line Status

This block is the receive half of a serial port. It watches an asynchronous RX line and uses a baud enable pulse that arrives sixteen times per bit. When it finds a start bit that holds until mid-bit, it frames a character of 5 to 8 data bits, taken least significant bit first. An optional parity bit and one or two stop bits may follow. Each finished character goes into a receive FIFO (64 entries by default) together with its own parity-error, framing-error and break tags. The tags leave the FIFO with their character, so the status shown always belongs to the character the host reads next.

The host sees the head character and its tags on a read port. It removes the head by pulsing a pop strobe. An overrun flag latches when a character finishes while the FIFO is full. That character is thrown away and the stored entries are not touched. The flag stays set until the host pulses the status-read strobe. A line held low for a whole frame is reported once, as a single break character. After that the receiver waits for the line to go high before it looks for another start bit.

Top module: `uart_rx_line`

## Requirements
- R1: While reset is asserted and just after it is released, data ready, overrun, parity error, framing error and break all read 0.
- R2: Data ready is 1 exactly when the FIFO holds at least one character. A pop strobe removes the head. A pop strobe with an empty FIFO has no effect.
- R3: Data bits are sampled at mid-bit, least significant bit first. The count is set by `cfg_len`: 00=5, 01=6, 10=7, 11=8 bits. Unused upper bits of `rd_data` read 0.
- R4: A falling edge starts a character only if RX is still low at the mid-bit sample of the start bit. A shorter low pulse returns the receiver to idle, and nothing is stored.
- R5: When `cfg_par_en` is 1, a parity bit follows the data. `cfg_par_mode` selects how it is checked: 00 means the data bits plus the parity bit hold an odd number of ones, 01 means they hold an even number, 10 means the parity bit must be 1, and 11 means it must be 0. A mismatch sets the head character's parity-error tag.
- R6: The framing-error tag is set when a stop bit is sampled low. With `cfg_two_stop`=1, both stop bits are checked.
- R7: If RX stays low through the whole frame (start, data, parity and stop bits), one entry is stored with data 0, break=1, framing error=1 and parity error=0. A continuous low stores no further entries. A new start bit is accepted only after RX has been seen high.
- R8: A character that finishes while the FIFO is full is dropped, the stored entries stay as they were, and overrun becomes 1. Overrun stays 1 until a status-read strobe clears it.
- R9: The parity-error, framing-error and break outputs show the tags of the current head entry. They follow the new head after each pop, and they read 0 when the FIFO is empty.
- R10: The FIFO delivers characters in the order they arrived and holds `FIFO_DEPTH` entries (64 by default, a power of two).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| baud_tick | input | 1 | Enable pulse, OSR per bit time |
| rx | input | 1 | Serial receive line, idle high |
| cfg_len | input | 2 | Data bit count code (5 to 8) |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_mode | input | 2 | Parity check mode |
| cfg_two_stop | input | 1 | Two stop bits |
| pop_strobe | input | 1 | Remove head character |
| status_rd | input | 1 | Status read, clears overrun |
| rd_data | output | 8 | Head character data |
| st_ready | output | 1 | At least one character stored |
| st_overrun | output | 1 | Sticky overrun flag |
| st_parity_err | output | 1 | Head character parity error |
| st_frame_err | output | 1 | Head character framing error |
| st_break | output | 1 | Head character is a break |

## Verification
The bench builds the block with `FIFO_DEPTH`=4 and the default `OSR`=16. It drives a baud tick every second clock, so one bit lasts 32 clocks. With only four entries, overrun takes five characters to reach, not sixty-five. That keeps the dropped-character check, the intact-contents check and the sticky-flag check within a short run. It also makes the pointer wraparound happen several times during the vector walk.

// File: rtl/uart_rx_line_pkg.sv
// Shared types for the UART receive path.
// Assumes: none; pure type and constant definitions.
package uart_rx_line_pkg;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PAR,
        RX_STOP,
        RX_BRKWAIT
    } rx_state_e;

    typedef struct packed {
        logic       brk;
        logic       fe;
        logic       pe;
        logic [7:0] data;
    } rx_entry_t;

    localparam logic [1:0] PAR_ODD   = 2'b00;
    localparam logic [1:0] PAR_EVEN  = 2'b01;
    localparam logic [1:0] PAR_ONE   = 2'b10;
    localparam logic [1:0] PAR_ZERO  = 2'b11;

endpackage

// File: rtl/uart_rx_framer.sv
// Character framer: validates the start bit, samples each bit at mid-bit,
// checks parity and stop bits, detects break and emits one tagged entry.
// Assumes: baud_tick pulses OSR times per bit; cfg_* stable during a frame.
module uart_rx_framer
    import uart_rx_line_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       baud_tick,
    input  logic       rx,
    input  logic [1:0] cfg_len,
    input  logic       cfg_par_en,
    input  logic [1:0] cfg_par_mode,
    input  logic       cfg_two_stop,
    output logic       push,
    output rx_entry_t  entry
);
    localparam int CW   = $clog2(OSR);
    localparam int HALF = OSR / 2;

    rx_state_e      state;
    logic [CW-1:0]  tick_cnt;
    logic [2:0]     bit_cnt;
    logic           stop_cnt;
    logic [7:0]     shreg;
    logic           par_bit;
    logic           all_low;
    logic           stop_bad;
    logic [3:0]     nbits;
    logic [7:0]     aligned;
    logic           par_err;
    logic           fin_low;
    logic           fin_bad;

    // Derive data width, right-aligned data and the parity verdict.
    always_comb begin
        nbits   = {2'b00, cfg_len} + 4'd5;
        aligned = shreg >> (4'd8 - nbits);
        fin_low = all_low & ~rx;
        fin_bad = stop_bad | ~rx;
        case (cfg_par_mode)
            PAR_ODD:  par_err = ~(^aligned ^ par_bit);
            PAR_EVEN: par_err = ^aligned ^ par_bit;
            PAR_ONE:  par_err = ~par_bit;
            default:  par_err = par_bit;
        endcase
        par_err = par_err & cfg_par_en;
    end

    // Frame state machine driven by the oversampling tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= RX_IDLE;
            tick_cnt <= '0;
            bit_cnt  <= '0;
            stop_cnt <= 1'b0;
            shreg    <= '0;
            par_bit  <= 1'b0;
            all_low  <= 1'b0;
            stop_bad <= 1'b0;
            push     <= 1'b0;
            entry    <= '0;
        end else begin
            push <= 1'b0;
            if (baud_tick) begin
                case (state)
                    RX_IDLE: begin
                        if (!rx) begin
                            state    <= RX_START;
                            tick_cnt <= '0;
                        end
                    end
                    RX_START: begin
                        if (tick_cnt == CW'(HALF - 1)) begin
                            tick_cnt <= '0;
                            if (rx) begin
                                state <= RX_IDLE;
                            end else begin
                                state    <= RX_DATA;
                                bit_cnt  <= '0;
                                shreg    <= '0;
                                all_low  <= 1'b1;
                                stop_bad <= 1'b0;
                            end
                        end else begin
                            tick_cnt <= tick_cnt + 1'b1;
                        end
                    end
                    RX_DATA: begin
                        if (tick_cnt == CW'(OSR - 1)) begin
                            tick_cnt <= '0;
                            shreg    <= {rx, shreg[7:1]};
                            all_low  <= all_low & ~rx;
                            bit_cnt  <= bit_cnt + 1'b1;
                            stop_cnt <= 1'b0;
                            if ({1'b0, bit_cnt} == nbits - 4'd1)
                                state <= cfg_par_en ? RX_PAR : RX_STOP;
                        end else begin
                            tick_cnt <= tick_cnt + 1'b1;
                        end
                    end
                    RX_PAR: begin
                        if (tick_cnt == CW'(OSR - 1)) begin
                            tick_cnt <= '0;
                            par_bit  <= rx;
                            all_low  <= all_low & ~rx;
                            state    <= RX_STOP;
                        end else begin
                            tick_cnt <= tick_cnt + 1'b1;
                        end
                    end
                    RX_STOP: begin
                        if (tick_cnt == CW'(OSR - 1)) begin
                            tick_cnt <= '0;
                            all_low  <= fin_low;
                            stop_bad <= fin_bad;
                            if (cfg_two_stop && !stop_cnt) begin
                                stop_cnt <= 1'b1;
                            end else begin
                                push       <= 1'b1;
                                entry.brk  <= fin_low;
                                entry.fe   <= fin_bad;
                                entry.pe   <= fin_low ? 1'b0 : par_err;
                                entry.data <= fin_low ? 8'h00 : aligned;
                                state      <= fin_low ? RX_BRKWAIT : RX_IDLE;
                            end
                        end else begin
                            tick_cnt <= tick_cnt + 1'b1;
                        end
                    end
                    default: begin
                        if (rx) state <= RX_IDLE;
                    end
                endcase
            end
        end
    end

    // A stored break always parks the receiver until the line is high (R7).
    p_brk_wait_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (push && entry.brk) |-> (state == RX_BRKWAIT));

    // A start pulse gone high by mid-bit returns to idle (R4).
    p_start_reject_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (baud_tick && state == RX_START && tick_cnt == CW'(HALF - 1) && rx)
        |=> (state == RX_IDLE && !push));

endmodule

// File: rtl/uart_rx_fifo.sv
// Show-ahead FIFO holding tagged receive entries; head is read combinationally.
// Assumes: DEPTH is a power of two; writer never writes when full.
module uart_rx_fifo
    import uart_rx_line_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr,
    input  rx_entry_t wdata,
    input  logic      rd,
    output rx_entry_t head,
    output logic      full,
    output logic      empty
);
    localparam int AW = $clog2(DEPTH);

    rx_entry_t     mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic [AW:0]   count;

    // Status and head view.
    always_comb begin
        full  = (count == (AW+1)'(DEPTH));
        empty = (count == '0);
        head  = mem[rd_ptr];
    end

    // Storage write port.
    always_ff @(posedge clk) begin
        if (wr && !full) mem[wr_ptr] <= wdata;
    end

    // Pointer and occupancy tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (wr && !full)  wr_ptr <= wr_ptr + 1'b1;
            if (rd && !empty) rd_ptr <= rd_ptr + 1'b1;
            count <= count + (AW+1)'(wr && !full) - (AW+1)'(rd && !empty);
        end
    end

    // Writer must respect the full flag (R8).
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr |-> !full);

    // A lone write grows occupancy by one (R10).
    p_count_up_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !rd && !full) |=> (count == $past(count) + 1'b1));

endmodule

// File: rtl/uart_rx_line.sv
// Top of the receive path: framer feeding a tagged FIFO, sticky overrun,
// and head-of-queue status presented to the host.
// Assumes: one pop per strobe cycle; status_rd is a single-cycle strobe.
module uart_rx_line
    import uart_rx_line_pkg::*;
#(
    parameter int FIFO_DEPTH = 64,
    parameter int OSR        = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       baud_tick,
    input  logic       rx,
    input  logic [1:0] cfg_len,
    input  logic       cfg_par_en,
    input  logic [1:0] cfg_par_mode,
    input  logic       cfg_two_stop,
    input  logic       pop_strobe,
    input  logic       status_rd,
    output logic [7:0] rd_data,
    output logic       st_ready,
    output logic       st_overrun,
    output logic       st_parity_err,
    output logic       st_frame_err,
    output logic       st_break
);
    logic      push;
    rx_entry_t entry;
    rx_entry_t head;
    logic      full;
    logic      empty;
    logic      do_wr;
    logic      do_rd;

    uart_rx_framer #(.OSR(OSR)) framer_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .baud_tick    (baud_tick),
        .rx           (rx),
        .cfg_len      (cfg_len),
        .cfg_par_en   (cfg_par_en),
        .cfg_par_mode (cfg_par_mode),
        .cfg_two_stop (cfg_two_stop),
        .push         (push),
        .entry        (entry)
    );

    uart_rx_fifo #(.DEPTH(FIFO_DEPTH)) fifo_i (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (do_wr),
        .wdata (entry),
        .rd    (do_rd),
        .head  (head),
        .full  (full),
        .empty (empty)
    );

    // Gate FIFO traffic and present the head entry.
    always_comb begin
        do_wr         = push && !full;
        do_rd         = pop_strobe && !empty;
        st_ready      = !empty;
        rd_data       = empty ? 8'h00 : head.data;
        st_parity_err = !empty && head.pe;
        st_frame_err  = !empty && head.fe;
        st_break      = !empty && head.brk;
    end

    // Sticky overrun: set on a dropped character, cleared by status read.
    always_ff @(posedge clk) begin
        if (!rst_n)              st_overrun <= 1'b0;
        else if (push && full)   st_overrun <= 1'b1;
        else if (status_rd)      st_overrun <= 1'b0;
    end

    // A dropped character always raises overrun (R8).
    p_ovr_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full) |=> st_overrun);

    // Overrun holds until a status read (R8).
    p_ovr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_overrun && !status_rd) |=> st_overrun);

    // Head entry and its tags do not move without a pop (R9).
    p_head_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!do_rd && !empty) |=> $stable(head));

endmodule

// File: tb/uart_rx_line_tb.sv
`timescale 1ns/1ps
module uart_rx_line_tb_top;

    localparam int DEPTH = 4;
    localparam int OSR   = 16;
    localparam int BITC  = OSR * 2;

    typedef struct packed {
        logic [1:0] len;
        logic       pen;
        logic [1:0] pm;
        logic       two;
        logic [7:0] d;
        logic       badp;
        logic [1:0] bads;
    } vec_t;

    localparam vec_t VECS [9] = '{
        '{2'd3, 1'b0, 2'd0, 1'b0, 8'hA5, 1'b0, 2'b00},
        '{2'd0, 1'b0, 2'd0, 1'b0, 8'hFF, 1'b0, 2'b00},
        '{2'd1, 1'b1, 2'd0, 1'b0, 8'h2C, 1'b0, 2'b00},
        '{2'd2, 1'b1, 2'd1, 1'b0, 8'h55, 1'b0, 2'b00},
        '{2'd3, 1'b1, 2'd2, 1'b0, 8'h00, 1'b0, 2'b00},
        '{2'd3, 1'b1, 2'd3, 1'b0, 8'h81, 1'b1, 2'b00},
        '{2'd3, 1'b0, 2'd0, 1'b1, 8'h3C, 1'b0, 2'b01},
        '{2'd2, 1'b1, 2'd1, 1'b1, 8'h7F, 1'b1, 2'b00},
        '{2'd3, 1'b0, 2'd0, 1'b1, 8'h12, 1'b0, 2'b10}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic       rx = 1'b1;
    logic [1:0] cfg_len = 2'd3;
    logic       cfg_par_en = 1'b0;
    logic [1:0] cfg_par_mode = 2'd0;
    logic       cfg_two_stop = 1'b0;
    logic       pop_strobe = 1'b0;
    logic       status_rd = 1'b0;
    logic [7:0] rd_data;
    logic       st_ready, st_overrun, st_parity_err, st_frame_err, st_break;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) begin
        baud_tick <= ~baud_tick;
        cycles    <= cycles + 1;
    end

    uart_rx_line #(.FIFO_DEPTH(DEPTH), .OSR(OSR)) dut_i (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .rx(rx),
        .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_mode(cfg_par_mode),
        .cfg_two_stop(cfg_two_stop), .pop_strobe(pop_strobe), .status_rd(status_rd),
        .rd_data(rd_data), .st_ready(st_ready), .st_overrun(st_overrun),
        .st_parity_err(st_parity_err), .st_frame_err(st_frame_err), .st_break(st_break)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic hold_bit(input logic v);
        rx = v;
        repeat (BITC) @(negedge clk);
    endtask

    task automatic send(input vec_t v);
        int n;
        logic [7:0] m;
        logic p;
        n = int'(v.len) + 5;
        m = v.d & (8'hFF >> (8 - n));
        case (v.pm)
            2'd0: p = ~(^m);
            2'd1: p = ^m;
            2'd2: p = 1'b1;
            default: p = 1'b0;
        endcase
        p = p ^ v.badp;
        cfg_len = v.len; cfg_par_en = v.pen; cfg_par_mode = v.pm; cfg_two_stop = v.two;
        hold_bit(1'b0);
        for (int i = 0; i < n; i++) hold_bit(m[i]);
        if (v.pen) hold_bit(p);
        hold_bit(~v.bads[0]);
        if (v.two) hold_bit(~v.bads[1]);
        hold_bit(1'b1);
    endtask

    task automatic send8(input logic [7:0] d);
        send('{2'd3, 1'b0, 2'd0, 1'b0, d, 1'b0, 2'b00});
    endtask

    task automatic pop();
        @(negedge clk); pop_strobe = 1'b1;
        @(negedge clk); pop_strobe = 1'b0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        while (cycles < 150000) @(negedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=<150000", cycles);
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state held during reset
        check("R1 ready in reset", st_ready, 0);
        check("R1 flags in reset", {st_overrun, st_parity_err, st_frame_err, st_break}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 ready after reset", st_ready, 0);
        check("R1 flags after reset", {st_overrun, st_parity_err, st_frame_err, st_break}, 0);

        // R2: pop with empty FIFO has no effect
        pop();
        check("R2 empty pop", {st_ready, st_overrun}, 0);

        // Vector walk: R3 widths, R5 parity modes, R6 stop checks
        for (int k = 0; k < 9; k++) begin
            logic [7:0] m;
            m = VECS[k].d & (8'hFF >> (3 - VECS[k].len));
            send(VECS[k]);
            @(negedge clk);
            check("R2 ready after char", st_ready, 1);
            check("R3 data", rd_data, m);
            check("R5 parity tag", st_parity_err, VECS[k].pen & VECS[k].badp);
            check("R6 frame tag", st_frame_err, |VECS[k].bads);
            check("R7 no break", st_break, 0);
            pop();
            check("R2 ready after pop", st_ready, 0);
        end

        // R4: short low pulse is rejected
        rx = 1'b0; repeat (6) @(negedge clk); rx = 1'b1;
        repeat (BITC * 12) @(negedge clk);
        check("R4 glitch stores nothing", st_ready, 0);

        // R9: tags follow the head across a pop
        send('{2'd3, 1'b1, 2'd1, 1'b0, 8'h5A, 1'b1, 2'b00});
        send('{2'd3, 1'b1, 2'd1, 1'b0, 8'hC3, 1'b0, 2'b00});
        @(negedge clk);
        check("R9 head data", rd_data, 8'h5A);
        check("R9 head parity tag", st_parity_err, 1);
        pop();
        check("R10 second data", rd_data, 8'hC3);
        check("R9 new head tag", st_parity_err, 0);
        pop();
        check("R9 tags zero when empty", {st_ready, st_parity_err, st_frame_err, st_break}, 0);

        // R7: sustained break stores one entry
        cfg_par_en = 1'b0; cfg_two_stop = 1'b0; cfg_len = 2'd3;
        rx = 1'b0;
        repeat (BITC * 30) @(negedge clk);
        check("R7 break stored", st_ready, 1);
        check("R7 break tags", {st_break, st_frame_err, st_parity_err}, 3'b110);
        check("R7 break data", rd_data, 0);
        pop();
        repeat (BITC * 2) @(negedge clk);
        check("R7 single break entry", st_ready, 0);
        rx = 1'b1;
        repeat (BITC * 2) @(negedge clk);
        send8(8'h96);
        @(negedge clk);
        check("R7 recovery data", rd_data, 8'h96);
        check("R7 recovery tags", {st_break, st_frame_err}, 0);
        pop();

        // R8/R10: overrun drops new character, keeps contents, sticky until read
        send8(8'h11); send8(8'h22); send8(8'h33); send8(8'h44);
        @(negedge clk);
        check("R8 no overrun yet", st_overrun, 0);
        send8(8'h55);
        @(negedge clk);
        check("R8 overrun set", st_overrun, 1);
        check("R8 head intact", rd_data, 8'h11);
        for (int j = 0; j < 4; j++) begin
            check("R10 fifo order", rd_data, 8'h11 * (j + 1));
            pop();
        end
        check("R8 dropped char absent", st_ready, 0);
        check("R8 overrun sticky", st_overrun, 1);
        @(negedge clk); status_rd = 1'b1;
        @(negedge clk); status_rd = 1'b0;
        check("R8 overrun cleared", st_overrun, 0);

        finish_run();
    end

endmodule